// File: doc/BRIEF.md
# PLL Clock Bring-Up Sequencer

This block brings up a system PLL and moves the system clock onto it after a single start pulse. It steps through a fixed safe order. First it bypasses the PLL and then powers it down. Next it applies a new reference source and forces the system divider to its fastest setting. It then loads the multiplier and divider word, which also powers the PLL on. After that it waits for lock and asks an external clock comparator to check the frequency. The block enforces a minimum wait after each step that needs one. All of these waits come from one shared down-counter.

The switchover only happens after the frequency check passes. Before switching, the divider is set one code above the target to limit the current step. The PLL clock is then enabled, and the target divider is written after a settling interval. A failed check or a missing lock leaves the PLL bypassed and raises the error flag. The PLL and the comparator are outside the block: it only drives their register-style controls and reads their status lines.

Top module: `pll_bringup_seq`

## Requirements
- R1: Out of reset all outputs are 0: the PLL is bypassed (`pll_clk_en_o`=0) and powered off, the source select is code 0 (internal oscillator), the config word is 0 and the divider is code 0. Divider code 0 means /1, and a larger code means a slower clock.
- R2: Start is sampled at edge S. At edge S the sequencer clears `pll_clk_en_o` and sets `busy_o`. It clears `pll_pwr_en_o` exactly 120 cycles later, at edge S+120.
- R3: `src_sel_o` takes `src_sel_i` 60 cycles after power-down, at edge S+180.
- R4: The source select changes only while the PLL is both bypassed and powered off. The divider is forced to code 0 at edge S+480, which is 300 cycles after the source change and one cycle before the PLL is programmed.
- R5: At edge S+481, `pll_cfg_o` takes the whole `pll_cfg_i` word in one cycle and `pll_pwr_en_o` rises at the same edge.
- R6: The sequencer waits for `pll_lock_i`. If lock is sampled high at edge K, `fchk_req_o` rises at edge K. It stays high until `fchk_done_i` is sampled.
- R7: `lock_timeout_i` = T. If lock is still low at edge S+482+T, the sequencer enters error at that edge (`err_o`=1, `busy_o`=0). A lock seen at or before that edge wins.
- R8: If `fchk_done_i` is sampled with `fchk_pass_i`=0, then at that edge `fchk_req_o` drops and the sequencer enters error. `pll_clk_en_o` stays 0.
- R9: On a passing check at edge E, `fchk_req_o` drops and the divider becomes target+1, saturating at the all-ones code. `pll_clk_en_o` rises at E+1. At E+201 the divider becomes the target, `busy_o` drops and `done_o` rises.
- R10: A start pulse while `busy_o`=1 has no effect on the sequence or its timing.
- R11: `done_o` and `err_o` hold until the next start. A start in either state restarts the full sequence.
- R12: At most one of `busy_o`, `done_o` and `err_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| src_sel_i | input | SRC_W | Reference source to apply |
| pll_cfg_i | input | CFG_W | Packed multiplier and divider word |
| sys_div_i | input | DIV_W | Final system divider code |
| lock_timeout_i | input | TO_W | Lock wait limit in cycles |
| pll_lock_i | input | 1 | PLL lock status |
| fchk_done_i | input | 1 | Frequency check result valid |
| fchk_pass_i | input | 1 | Frequency check in range |
| pll_clk_en_o | output | 1 | 1 = system clock from PLL, 0 = bypassed |
| pll_pwr_en_o | output | 1 | PLL power enable |
| src_sel_o | output | SRC_W | Applied reference source |
| pll_cfg_o | output | CFG_W | Applied PLL config word |
| sys_div_o | output | DIV_W | System divider code |
| fchk_req_o | output | 1 | Frequency check request |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Switchover complete |
| err_o | output | 1 | Sequence aborted |

## Verification
Some ordering rules are checked by assertions on every cycle. The source select changes only while the PLL is bypassed and off. The config word moves only when power rises, and the divider is at /1 whenever power rises. The pre-switch divider is target+1 when the PLL clock is enabled. The error state keeps the PLL bypassed, and the status flags are exclusive. The exact spacing between steps can only be shown by the bench's scenarios. The same holds for lock-timeout and check-fail aborts, divider saturation, ignored starts and restart from done or error. The bench compares every output change against a timed expected list.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BYP, ST_PWR, ST_SRC, ST_LOAD, ST_LOCK,
    ST_FCHK, ST_SWON, ST_SETTLE, ST_DONE, ST_ERR
  } pll_st_e;

  // one-cycle action strobes from fsm to output registers
  typedef struct packed {
    logic bypass;
    logic pwrdn;
    logic src;
    logic div1;
    logic load;
    logic req_on;
    logic req_off;
    logic prediv;
    logic swon;
    logic fin;
    logic err;
  } pll_act_t;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o); // R2
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int TO_W      = 16,
  parameter int BYP_WAIT  = 120,
  parameter int PWR_WAIT  = 60,
  parameter int SRC_WAIT  = 300,
  parameter int SW_WAIT   = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TO_W-1:0]  lock_timeout_i,
  input  logic             pll_lock_i,
  input  logic             fchk_done_i,
  input  logic             fchk_pass_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output pll_act_t         act_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  pll_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    act_o      = '0;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_ERR: if (start_i) begin
        st_d = ST_BYP;
        act_o.bypass = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(BYP_WAIT - 1);
      end
      ST_BYP: if (tmr_zero_i) begin
        st_d = ST_PWR;
        act_o.pwrdn = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(PWR_WAIT - 1);
      end
      ST_PWR: if (tmr_zero_i) begin
        st_d = ST_SRC;
        act_o.src = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(SRC_WAIT - 1);
      end
      ST_SRC: if (tmr_zero_i) begin
        st_d = ST_LOAD;
        act_o.div1 = 1'b1;
      end
      ST_LOAD: begin
        st_d = ST_LOCK;
        act_o.load = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(lock_timeout_i);
      end
      ST_LOCK: begin
        if (pll_lock_i) begin
          st_d = ST_FCHK;
          act_o.req_on = 1'b1;
        end else if (tmr_zero_i) begin
          st_d = ST_ERR;
          act_o.err = 1'b1;
        end
      end
      ST_FCHK: if (fchk_done_i) begin
        act_o.req_off = 1'b1;
        if (fchk_pass_i) begin
          st_d = ST_SWON;
          act_o.prediv = 1'b1;
        end else begin
          st_d = ST_ERR;
          act_o.err = 1'b1;
        end
      end
      ST_SWON: begin
        st_d = ST_SETTLE;
        act_o.swon = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(SW_WAIT - 1);
      end
      ST_SETTLE: if (tmr_zero_i) begin
        st_d = ST_DONE;
        act_o.fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign done_o = (st_q == ST_DONE);
  assign err_o  = (st_q == ST_ERR);
  assign busy_o = !(st_q == ST_IDLE || done_o || err_o);

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, err_o})); // R12
  AST_BYP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BYP && !tmr_zero_i) |=> st_q == ST_BYP); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && st_q != ST_BYP) |=> st_q != ST_BYP); // R10
endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter int CFG_W = 32,
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pll_act_t         act_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic [CFG_W-1:0] pll_cfg_i,
  input  logic [DIV_W-1:0] sys_div_i,
  output logic             pll_clk_en_o,
  output logic             pll_pwr_en_o,
  output logic [SRC_W-1:0] src_sel_o,
  output logic [CFG_W-1:0] pll_cfg_o,
  output logic [DIV_W-1:0] sys_div_o,
  output logic             fchk_req_o
);
  logic [DIV_W-1:0] tgt_q, div_inc;

  // one code slower than target, saturating
  assign div_inc = (tgt_q == '1) ? tgt_q : tgt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_clk_en_o <= 1'b0;
      pll_pwr_en_o <= 1'b0;
      src_sel_o    <= '0;
      pll_cfg_o    <= '0;
      sys_div_o    <= '0;
      fchk_req_o   <= 1'b0;
      tgt_q        <= '0;
    end else begin
      if (act_i.bypass) begin
        pll_clk_en_o <= 1'b0;
        tgt_q        <= sys_div_i;
      end
      if (act_i.pwrdn)  pll_pwr_en_o <= 1'b0;
      if (act_i.src)    src_sel_o    <= src_sel_i;
      if (act_i.div1)   sys_div_o    <= '0;
      if (act_i.load) begin
        pll_cfg_o    <= pll_cfg_i;
        pll_pwr_en_o <= 1'b1;
      end
      if (act_i.req_on)  fchk_req_o <= 1'b1;
      if (act_i.req_off) fchk_req_o <= 1'b0;
      if (act_i.prediv)  sys_div_o  <= div_inc;
      if (act_i.swon)    pll_clk_en_o <= 1'b1;
      if (act_i.fin)     sys_div_o  <= tgt_q;
      if (act_i.err) begin
        pll_clk_en_o <= 1'b0;
        fchk_req_o   <= 1'b0;
      end
    end
  end

  AST_SRC_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_sel_o) |-> $past(!pll_clk_en_o && !pll_pwr_en_o)); // R4
  AST_DIV1_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_pwr_en_o) |-> (sys_div_o == '0) && !pll_clk_en_o); // R4
  AST_CFG_WITH_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_cfg_o) |-> $rose(pll_pwr_en_o)); // R5
  AST_PREDIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_clk_en_o) |-> sys_div_o == div_inc && pll_pwr_en_o); // R9
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int SRC_W    = 2,
  parameter int CFG_W    = 32,
  parameter int DIV_W    = 4,
  parameter int TO_W     = 16,
  parameter int BYP_WAIT = 120,
  parameter int PWR_WAIT = 60,
  parameter int SRC_WAIT = 300,
  parameter int SW_WAIT  = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic [CFG_W-1:0] pll_cfg_i,
  input  logic [DIV_W-1:0] sys_div_i,
  input  logic [TO_W-1:0]  lock_timeout_i,
  input  logic             pll_lock_i,
  input  logic             fchk_done_i,
  input  logic             fchk_pass_i,
  output logic             pll_clk_en_o,
  output logic             pll_pwr_en_o,
  output logic [SRC_W-1:0] src_sel_o,
  output logic [CFG_W-1:0] pll_cfg_o,
  output logic [DIV_W-1:0] sys_div_o,
  output logic             fchk_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int WMAX_A = (BYP_WAIT > PWR_WAIT) ? BYP_WAIT : PWR_WAIT;
  localparam int WMAX_B = (SRC_WAIT > SW_WAIT) ? SRC_WAIT : SW_WAIT;
  localparam int WMAX   = (WMAX_A > WMAX_B) ? WMAX_A : WMAX_B;
  localparam int WAIT_W = $clog2(WMAX + 1);
  localparam int CNT_W  = (TO_W > WAIT_W) ? TO_W : WAIT_W;

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  pll_act_t         act;

  pll_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pll_seq_fsm #(
    .CNT_W(CNT_W), .TO_W(TO_W), .BYP_WAIT(BYP_WAIT),
    .PWR_WAIT(PWR_WAIT), .SRC_WAIT(SRC_WAIT), .SW_WAIT(SW_WAIT)
  ) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .lock_timeout_i (lock_timeout_i),
    .pll_lock_i     (pll_lock_i),
    .fchk_done_i    (fchk_done_i),
    .fchk_pass_i    (fchk_pass_i),
    .tmr_zero_i     (tmr_zero),
    .tmr_load_o     (tmr_load),
    .tmr_val_o      (tmr_val),
    .act_o          (act),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o)
  );

  pll_seq_regs #(.SRC_W(SRC_W), .CFG_W(CFG_W), .DIV_W(DIV_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (act),
    .src_sel_i    (src_sel_i),
    .pll_cfg_i    (pll_cfg_i),
    .sys_div_i    (sys_div_i),
    .pll_clk_en_o (pll_clk_en_o),
    .pll_pwr_en_o (pll_pwr_en_o),
    .src_sel_o    (src_sel_o),
    .pll_cfg_o    (pll_cfg_o),
    .sys_div_o    (sys_div_o),
    .fchk_req_o   (fchk_req_o)
  );

  AST_ERR_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pll_clk_en_o); // R8
  AST_DONE_ON_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pll_clk_en_o && pll_pwr_en_o && !fchk_req_o); // R9
endmodule

// File: tb/test_pll_bringup_seq.sv
module test_pll_bringup_seq;
  localparam int SRC_W = 2, CFG_W = 32, DIV_W = 4, TO_W = 16;

  typedef struct packed {
    logic             clk_en;
    logic             pwr;
    logic [SRC_W-1:0] src;
    logic [CFG_W-1:0] cfg;
    logic [DIV_W-1:0] div;
    logic             req;
    logic             busy;
    logic             done;
    logic             err;
  } snap_t;

  typedef struct {
    int    cyc;
    snap_t snap;
    string tag;
  } item_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [SRC_W-1:0] src_sel_i = '0;
  logic [CFG_W-1:0] pll_cfg_i = '0;
  logic [DIV_W-1:0] sys_div_i = '0;
  logic [TO_W-1:0]  lock_timeout_i = '0;
  logic pll_lock_i = 1'b0, fchk_done_i = 1'b0, fchk_pass_i = 1'b0;
  logic pll_clk_en_o, pll_pwr_en_o, fchk_req_o, busy_o, done_o, err_o;
  logic [SRC_W-1:0] src_sel_o;
  logic [CFG_W-1:0] pll_cfg_o;
  logic [DIV_W-1:0] sys_div_o;

  int    cyc = 0, checks = 0, errors = 0;
  item_t q[$];
  snap_t model, prev;
  bit    mon_en = 1'b0, finished = 1'b0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pll_bringup_seq i_pll_bringup_seq (.*);

  function automatic snap_t cur();
    return '{pll_clk_en_o, pll_pwr_en_o, src_sel_o, pll_cfg_o, sys_div_o,
             fchk_req_o, busy_o, done_o, err_o};
  endfunction

  task automatic chk(bit ok, string tag, string what, snap_t act, snap_t exp,
                     int act_c, int exp_c);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h @%0d expected=%h @%0d",
               tag, what, act, act_c, exp, exp_c);
    end
  endtask

  // driver side: queue an expected output change if the model moved
  task automatic expect_at(int c, string tag);
    item_t it;
    if (model != prev_push) begin
      it.cyc = c; it.snap = model; it.tag = tag;
      q.push_back(it);
      prev_push = model;
    end
  endtask
  snap_t prev_push;

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  // monitor: every output change is popped and compared
  always @(negedge clk_i) begin
    if (mon_en) begin
      snap_t s;
      s = cur();
      if (s != prev) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected change", s, prev, cyc, -1);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(it.cyc == cyc && it.snap == s, it.tag, "output change", s,
              it.snap, cyc, it.cyc);
        end
        prev = s;
      end
    end
  end

  task automatic run(input logic [SRC_W-1:0] src, input logic [CFG_W-1:0] cfg,
                     input logic [DIV_W-1:0] div, input int t, input int l,
                     input int f, input bit pass, input bit poke);
    int s, e, fin;
    snap_t none;
    none = '0;
    pll_lock_i = 1'b0; fchk_done_i = 1'b0; fchk_pass_i = 1'b0;
    src_sel_i = src; pll_cfg_i = cfg; sys_div_i = div;
    lock_timeout_i = TO_W'(t);
    start_i = 1'b1;
    s = cyc + 1;
    model.clk_en = 1'b0; model.busy = 1'b1; model.done = 1'b0; model.err = 1'b0;
    expect_at(s, "R2 R11");
    model.pwr = 1'b0;  expect_at(s + 120, "R2");
    model.src = src;   expect_at(s + 180, "R3 R10");
    model.div = '0;    expect_at(s + 480, "R4");
    model.cfg = cfg; model.pwr = 1'b1; expect_at(s + 481, "R5");
    if (l > t) begin
      model.err = 1'b1; model.busy = 1'b0; expect_at(s + 482 + t, "R7");
      fin = s + 482 + t;
    end else begin
      model.req = 1'b1; expect_at(s + 482 + l, "R6");
      e = s + 483 + l + f;
      model.req = 1'b0;
      if (pass) begin
        model.div = (div == '1) ? div : div + 1'b1; expect_at(e, "R9");
        model.clk_en = 1'b1; expect_at(e + 1, "R9");
        model.div = div; model.busy = 1'b0; model.done = 1'b1;
        expect_at(e + 201, "R9");
        fin = e + 201;
      end else begin
        model.err = 1'b1; model.busy = 1'b0; expect_at(e, "R8");
        fin = e;
      end
    end
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      wait_to(s + 150);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    if (l <= t) begin
      wait_to(s + 481 + l);
      pll_lock_i = 1'b1;
      if (poke) begin
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end
      wait_to(s + 482 + l + f);
      fchk_done_i = 1'b1; fchk_pass_i = pass;
      @(negedge clk_i);
      fchk_done_i = 1'b0; fchk_pass_i = 1'b0;
    end
    wait_to(fin + 20);
    chk(q.size() == 0, "R11", "pending expected items", none, none, q.size(), 0);
    chk(done_o == (pass && l <= t) && err_o == !(pass && l <= t) && !busy_o,
        "R11", "status held", cur(), model, cyc, fin);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    model = '0; prev = '0; prev_push = '0;
    chk(cur() == '0, "R1", "reset state", cur(), '0, cyc, cyc);
    mon_en = 1'b1;
    @(negedge clk_i);
    run(2'd2, 32'hA5C3_1E07, 4'd3, 40, 12, 4, 1'b1, 1'b1);
    run(2'd1, 32'h0F0F_3C3C, 4'hF, 20, 0, 0, 1'b1, 1'b0);
    run(2'd1, 32'h1234_5678, 4'd2, 30, 5, 7, 1'b0, 1'b0);
    run(2'd3, 32'h0BAD_F00D, 4'd1, 8, 9, 0, 1'b1, 1'b0);
    run(2'd0, 32'hFFFF_0001, 4'd0, 6, 6, 0, 1'b1, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule